// File: doc/BRIEF.md
# Configurable Pad Input/Output Cell

This block connects core logic to a group of bidirectional pads, one lane per pad. On the way out, each lane's data can be inverted under a configuration bit. It then reaches the pad either straight from the core or through an output register that the output clock loads. Each lane's driver has its own enable from the core, and one configuration bit sets the polarity of every enable. A pad that neither the cell nor any outside agent drives can be held high by a configurable passive pull-up.

On the way in, the core receives the resolved pad level in two forms. One is a direct copy. The other is a copy registered on the input clock, which is separate from the output clock. A single active-high reset clears both registers, synchronously to each register's own clock. A slew-rate flag is not used inside the cell and goes straight to the pad driver.

The pad itself is modelled with three pieces of information: the cell's drive value, the cell's drive enable, and an outside agent that may drive each pad. From these the cell resolves the level that the core sees.

Top module: `pad_io_cell`

## Requirements
- R1: Each bit of `pad_oe` equals the matching bit of `core_oe` when `cfg_oe_inv` is 0, and its inverse when `cfg_oe_inv` is 1.
- R2: With `cfg_out_reg` = 0 (direct mode), `pad_out` equals `core_dout` when `cfg_out_inv` is 0 and `~core_dout` when it is 1, with no clock involved.
- R3: With `cfg_out_reg` = 1 (registered mode), `pad_out` shows `core_dout` XOR `cfg_out_inv` as sampled at the most recent rising edge of `clk_out`, and holds that value between edges.
- R4: `pad_in` is the resolved pad level, available to the core with no clock delay.
- R5: `core_din_reg` takes the value of `pad_in` at each rising edge of `clk_in`, and holds between `clk_in` edges.
- R6: A rising edge of a clock with `rst` high clears the register on that clock to 0. In registered mode `pad_out` is then 0, and `core_din_reg` is 0.
- R7: A pad bit with `pad_oe` = 0 and `ext_drive` = 0 reads 1 on `pad_in` when `cfg_pull_en` = 1, and 0 when `cfg_pull_en` = 0.
- R8: Where `pad_oe` is 1, `pad_in` equals `pad_out`, whatever the outside agent does on that bit.
- R9: Where `pad_oe` is 0 and `ext_drive` is 1, `pad_in` equals `ext_level`.
- R10: `slew_fast` follows `cfg_slew_fast` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_out | input | 1 | Clock of the output register |
| clk_in | input | 1 | Clock of the input register |
| rst | input | 1 | Active-high reset, synchronous to each clock |
| cfg_out_inv | input | 1 | Invert output data |
| cfg_oe_inv | input | 1 | Invert driver enable polarity |
| cfg_out_reg | input | 1 | 1 selects the registered output, 0 the direct output |
| cfg_pull_en | input | 1 | Enable passive pull-up on undriven pads |
| cfg_slew_fast | input | 1 | Fast-slew request for the driver |
| core_dout | input | W | Output data from the core |
| core_oe | input | W | Driver enable from the core, before polarity |
| ext_drive | input | W | Outside agent drives the pad (per bit) |
| ext_level | input | W | Level driven by the outside agent |
| pad_out | output | W | Value the cell drives onto the pad |
| pad_oe | output | W | Cell driver enable |
| pad_in | output | W | Resolved pad level, direct copy for the core |
| core_din_reg | output | W | Pad level registered on clk_in |
| slew_fast | output | 1 | Slew flag forwarded to the driver |

## Verification
A stale or wrongly cleared output register shows on `pad_out` only in registered mode. It appears at the first `clk_out` edge after the fault, and after reset it shows as a nonzero pad value. A fault in the input register shows on `core_din_reg` one `clk_in` edge after the pad level changes. Faults in the pad resolution or in the polarity logic show at once on `pad_in` or `pad_oe`. They are caught by driving each combination of own drive, outside drive and pull-up, and comparing the result with the value the requirements give.

// File: rtl/pad_io_pkg.sv
package pad_io_pkg;

    typedef enum logic {
        OUT_DIRECT = 1'b0,
        OUT_FLOP   = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic      data_inv;
        logic      en_inv;
        out_mode_e mode;
    } out_ctrl_t;

    // Level seen on one pad: own driver first, then outside agent, then pull-up.
    function automatic logic resolve_level(
        input logic own_en,
        input logic own_val,
        input logic far_en,
        input logic far_val,
        input logic pull_on
    );
        logic lvl;
        if (own_en)
            lvl = own_val;
        else if (far_en)
            lvl = far_val;
        else
            lvl = pull_on;
        return lvl;
    endfunction

endpackage

// File: rtl/pad_io_out_path.sv
module pad_io_out_path
    import pad_io_pkg::*;
#(
    parameter int W = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  out_ctrl_t     ctrl,
    input  logic [W-1:0]  dout,
    input  logic [W-1:0]  oe,
    output logic [W-1:0]  drv_val,
    output logic [W-1:0]  drv_en
);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] polar_q;
    logic [W-1:0] flop_q;

    assign polar_q = dout ^ {W{ctrl.data_inv}};

    always_ff @(posedge clk) begin
        if (rst)
            flop_q <= ZERO;
        else
            flop_q <= polar_q;
    end

    always_comb begin
        if (ctrl.mode == OUT_FLOP)
            drv_val = flop_q;
        else
            drv_val = polar_q;
    end

    assign drv_en = oe ^ {W{ctrl.en_inv}};

endmodule

// File: rtl/pad_io_resolve.sv
module pad_io_resolve
    import pad_io_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] own_en,
    input  logic [W-1:0] own_val,
    input  logic [W-1:0] far_en,
    input  logic [W-1:0] far_val,
    input  logic         pull_on,
    output logic [W-1:0] level
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign level[i] = resolve_level(own_en[i], own_val[i],
                                        far_en[i], far_val[i], pull_on);
    end
endmodule

// File: rtl/pad_io_in_path.sv
module pad_io_in_path #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    output logic [W-1:0] level_q
);
    localparam logic [W-1:0] ZERO = '0;

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= ZERO;
        else
            level_q <= level;
    end
endmodule

// File: rtl/pad_io_cell.sv
module pad_io_cell
    import pad_io_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk_out,
    input  logic         clk_in,
    input  logic         rst,
    input  logic         cfg_out_inv,
    input  logic         cfg_oe_inv,
    input  logic         cfg_out_reg,
    input  logic         cfg_pull_en,
    input  logic         cfg_slew_fast,
    input  logic [W-1:0] core_dout,
    input  logic [W-1:0] core_oe,
    input  logic [W-1:0] ext_drive,
    input  logic [W-1:0] ext_level,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_in,
    output logic [W-1:0] core_din_reg,
    output logic         slew_fast
);
    out_ctrl_t out_ctrl;

    assign out_ctrl.data_inv = cfg_out_inv;
    assign out_ctrl.en_inv   = cfg_oe_inv;
    assign out_ctrl.mode     = cfg_out_reg ? OUT_FLOP : OUT_DIRECT;

    pad_io_out_path #(.W(W)) out_i (
        .clk     (clk_out),
        .rst     (rst),
        .ctrl    (out_ctrl),
        .dout    (core_dout),
        .oe      (core_oe),
        .drv_val (pad_out),
        .drv_en  (pad_oe)
    );

    pad_io_resolve #(.W(W)) res_i (
        .own_en  (pad_oe),
        .own_val (pad_out),
        .far_en  (ext_drive),
        .far_val (ext_level),
        .pull_on (cfg_pull_en),
        .level   (pad_in)
    );

    pad_io_in_path #(.W(W)) in_i (
        .clk     (clk_in),
        .rst     (rst),
        .level   (pad_in),
        .level_q (core_din_reg)
    );

    assign slew_fast = cfg_slew_fast;

endmodule

// File: rtl/pad_io_cell_chk.sv
module pad_io_cell_chk #(
    parameter int W = 4
) (
    input logic         clk_out,
    input logic         clk_in,
    input logic         rst,
    input logic         cfg_out_inv,
    input logic         cfg_oe_inv,
    input logic         cfg_out_reg,
    input logic         cfg_pull_en,
    input logic         cfg_slew_fast,
    input logic [W-1:0] core_dout,
    input logic [W-1:0] core_oe,
    input logic [W-1:0] ext_drive,
    input logic [W-1:0] ext_level,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] core_din_reg,
    input logic         slew_fast
);
    logic ok_out;
    logic ok_in;

    always_ff @(posedge clk_out) begin
        if (rst) ok_out <= 1'b0;
        else     ok_out <= 1'b1;
    end

    always_ff @(posedge clk_in) begin
        if (rst) ok_in <= 1'b0;
        else     ok_in <= 1'b1;
    end

    a_r1_oe_plain: assert property (@(posedge clk_out) disable iff (rst)
        !cfg_oe_inv |-> pad_oe == core_oe);
    a_r1_oe_flipped: assert property (@(posedge clk_out) disable iff (rst)
        cfg_oe_inv |-> pad_oe == ~core_oe);
    a_r2_direct_data: assert property (@(posedge clk_out) disable iff (rst)
        !cfg_out_reg |-> pad_out == (cfg_out_inv ? ~core_dout : core_dout));
    a_r3_flop_data: assert property (@(posedge clk_out) disable iff (rst)
        (ok_out && cfg_out_reg) |->
        pad_out == ($past(core_dout) ^ {W{$past(cfg_out_inv)}}));
    a_r5_in_capture: assert property (@(posedge clk_in) disable iff (rst)
        ok_in |-> core_din_reg == $past(pad_in));
    a_r6_out_cleared: assert property (@(posedge clk_out) disable iff (rst)
        ($past(rst) === 1'b1 && cfg_out_reg) |-> pad_out == '0);
    a_r6_in_cleared: assert property (@(posedge clk_in) disable iff (rst)
        ($past(rst) === 1'b1) |-> core_din_reg == '0);
    a_r7_pull_high: assert property (@(posedge clk_out) disable iff (rst)
        cfg_pull_en |-> (pad_in & ~pad_oe & ~ext_drive) == (~pad_oe & ~ext_drive));
    a_r7_float_low: assert property (@(posedge clk_out) disable iff (rst)
        !cfg_pull_en |-> (pad_in & ~pad_oe & ~ext_drive) == '0);
    a_r8_own_wins: assert property (@(posedge clk_out) disable iff (rst)
        (pad_in & pad_oe) == (pad_out & pad_oe));
    a_r9_far_level: assert property (@(posedge clk_out) disable iff (rst)
        (pad_in & ext_drive & ~pad_oe) == (ext_level & ext_drive & ~pad_oe));
    a_r10_slew: assert property (@(posedge clk_out) disable iff (rst)
        slew_fast == cfg_slew_fast);

endmodule

bind pad_io_cell pad_io_cell_chk #(.W(W)) chk_i (
    .clk_out       (clk_out),
    .clk_in        (clk_in),
    .rst           (rst),
    .cfg_out_inv   (cfg_out_inv),
    .cfg_oe_inv    (cfg_oe_inv),
    .cfg_out_reg   (cfg_out_reg),
    .cfg_pull_en   (cfg_pull_en),
    .cfg_slew_fast (cfg_slew_fast),
    .core_dout     (core_dout),
    .core_oe       (core_oe),
    .ext_drive     (ext_drive),
    .ext_level     (ext_level),
    .pad_out       (pad_out),
    .pad_oe        (pad_oe),
    .pad_in        (pad_in),
    .core_din_reg  (core_din_reg),
    .slew_fast     (slew_fast)
);

// File: tb/pad_io_cell_tb_top.sv
module pad_io_cell_tb_top;
    localparam int W = 4;

    logic         clk_out = 1'b0;
    logic         clk_in  = 1'b0;
    logic         rst;
    logic         cfg_out_inv, cfg_oe_inv, cfg_out_reg, cfg_pull_en, cfg_slew_fast;
    logic [W-1:0] core_dout, core_oe, ext_drive, ext_level;
    logic [W-1:0] pad_out, pad_oe, pad_in, core_din_reg;
    logic         slew_fast;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk_out = ~clk_out;
    always #6 clk_in  = ~clk_in;

    pad_io_cell #(.W(W)) dut_i (
        .clk_out(clk_out), .clk_in(clk_in), .rst(rst),
        .cfg_out_inv(cfg_out_inv), .cfg_oe_inv(cfg_oe_inv),
        .cfg_out_reg(cfg_out_reg), .cfg_pull_en(cfg_pull_en),
        .cfg_slew_fast(cfg_slew_fast),
        .core_dout(core_dout), .core_oe(core_oe),
        .ext_drive(ext_drive), .ext_level(ext_level),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in),
        .core_din_reg(core_din_reg), .slew_fast(slew_fast)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cfg_out_inv = 0; cfg_oe_inv = 0; cfg_out_reg = 1;
        cfg_pull_en = 1; cfg_slew_fast = 0;
        core_dout = 4'hF; core_oe = 4'h0; ext_drive = 4'h0; ext_level = 4'h0;
        repeat (3) @(posedge clk_in);
        #1;
        check("R6 out reg cleared", pad_out, 4'h0);
        check("R6 in reg cleared", core_din_reg, 4'h0);
        rst = 1'b0;
    endtask

    task automatic t_oe_polarity();
        core_oe = 4'h5; cfg_oe_inv = 0; #1;
        check("R1 oe plain", pad_oe, 4'h5);
        cfg_oe_inv = 1; #1;
        check("R1 oe inverted", pad_oe, 4'hA);
        cfg_oe_inv = 0; core_oe = 4'h0; #1;
    endtask

    task automatic t_direct();
        cfg_out_reg = 0; cfg_out_inv = 0; core_dout = 4'h6; #1;
        check("R2 direct plain", pad_out, 4'h6);
        cfg_out_inv = 1; #1;
        check("R2 direct inverted", pad_out, 4'h9);
        cfg_out_inv = 0; #1;
    endtask

    task automatic t_flop();
        @(posedge clk_out); #1;
        cfg_out_reg = 1; cfg_out_inv = 0; core_dout = 4'hA; #1;
        @(posedge clk_out); #1;
        check("R3 flop captured", pad_out, 4'hA);
        core_dout = 4'h5; #1;
        check("R3 flop holds", pad_out, 4'hA);
        @(posedge clk_out); #1;
        check("R3 flop next", pad_out, 4'h5);
        cfg_out_inv = 1; #1;
        @(posedge clk_out); #1;
        check("R3 flop inverted", pad_out, 4'hA);
        cfg_out_reg = 0; cfg_out_inv = 0; #1;
    endtask

    task automatic t_resolve();
        core_oe = 4'h0; ext_drive = 4'h0; cfg_pull_en = 1; #1;
        check("R7 pull-up high", pad_in, 4'hF);
        cfg_pull_en = 0; #1;
        check("R7 floating low", pad_in, 4'h0);
        check("R4 raw matches level", pad_in, 4'h0);
        ext_drive = 4'hF; ext_level = 4'h3; #1;
        check("R9 outside level", pad_in, 4'h3);
        core_oe = 4'hF; core_dout = 4'hC; #1;
        check("R8 own driver wins", pad_in, 4'hC);
        core_oe = 4'h3; core_dout = 4'h0; ext_drive = 4'hC; ext_level = 4'hC; #1;
        check("R8 R9 mixed lanes", pad_in, 4'hC);
        core_oe = 4'h0; ext_drive = 4'h2; ext_level = 4'h0; cfg_pull_en = 1; #1;
        check("R7 R9 pull with partial drive", pad_in, 4'hD);
    endtask

    task automatic t_in_reg();
        core_oe = 4'h0; ext_drive = 4'hF; ext_level = 4'h9;
        @(posedge clk_in); #1;
        check("R5 in reg captured", core_din_reg, 4'h9);
        ext_level = 4'h6; #1;
        check("R5 in reg holds", core_din_reg, 4'h9);
        check("R4 raw follows pad", pad_in, 4'h6);
        @(posedge clk_in); #1;
        check("R5 in reg next", core_din_reg, 4'h6);
    endtask

    task automatic t_reset_again();
        cfg_out_reg = 1; core_dout = 4'hF; #1;
        @(posedge clk_out); #1;
        check("R3 flop loaded before reset", pad_out, 4'hF);
        rst = 1'b1;
        @(posedge clk_out); #1;
        check("R6 out reg cleared midrun", pad_out, 4'h0);
        @(posedge clk_in); #1;
        check("R6 in reg cleared midrun", core_din_reg, 4'h0);
        rst = 1'b0; cfg_out_reg = 0; #1;
    endtask

    task automatic t_slew();
        cfg_slew_fast = 0; #1;
        check("R10 slew slow", {3'b0, slew_fast}, 4'h0);
        cfg_slew_fast = 1; #1;
        check("R10 slew fast", {3'b0, slew_fast}, 4'h1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1;
        t_reset();
        t_oe_polarity();
        t_direct();
        t_flop();
        t_resolve();
        t_in_reg();
        t_reset_again();
        t_slew();
        finish_run();
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end
endmodule